// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between the command scheduler of a small DRAM controller and the command bus. Each cycle the scheduler offers at most one candidate command (activate, read, write or precharge) with a rank and a bank address. The guard answers in the same cycle with a grant. A grant is given only when the addressed bank is in the right open or closed state and every programmed minimum spacing since earlier commands has run out.

Each bank keeps its own row state and three down-counters:
- precharge-to-activate,
- activate-to-column,
- write-to-precharge.

Each rank keeps an activate-to-activate counter and a four-deep ring of countdowns that enforces the four-activate window. All timing inputs are in DRAM clock cycles and can be changed at run time. A value outside its legal range is clamped to the nearest limit.

A read-data-valid strobe marks the nominal cycle in which read data leaves the DRAM, a CAS latency after each granted read. It does not model where the data is captured.

Top module: `dram_timing_guard`

## Requirements
- R1: After reset every bank is closed, all spacing counters are expired and `rd_data_valid` is low. A read to any bank is therefore refused until that bank has been activated.
- R2: An activate is granted only to a closed bank. Read, write and precharge are granted only to an open bank. A granted activate opens the bank and a granted precharge closes it. Command codes: 0 = activate, 1 = read, 2 = write, 3 = precharge.
- R3: A read or write to a bank is granted only when at least tRCD cycles separate it from that bank's last activate.
- R4: An activate to a bank is granted only when at least tRP cycles separate it from that bank's last precharge.
- R5: A precharge to a bank is granted only when at least CL + 4 + tWR cycles separate it from that bank's last write. The 4 is the burst length in cycles.
- R6: Two activates to the same rank are granted only when at least tRRD cycles apart.
- R7: Any window of tFAW cycles contains at most four granted activates to one rank. A fifth activate waits until the oldest of the last four is at least tFAW cycles old.
- R8: `rd_data_valid` is high for exactly one cycle, CL cycles after the cycle in which a read is granted.
- R9: Out-of-range timing inputs are clamped to these limits:
  - CL: 5..15
  - tRP: 4..15
  - tRCD: 4..15
  - tRRD: 4..15
  - tWR: 5..16
  - tFAW: 4·tRRD..63
- R10: Spacing and window limits of one rank never block activates to another rank.
- R11: With `cmd_valid` low there is no grant, and the offered command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A candidate command is offered |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bank | input | BANK_W | Target bank within the rank |
| cfg_cl | input | 4 | CAS latency |
| cfg_trp | input | 4 | Precharge-to-activate spacing |
| cfg_trcd | input | 4 | Activate-to-column spacing |
| cfg_trrd | input | 4 | Activate-to-activate spacing, same rank |
| cfg_twr | input | 5 | Write recovery |
| cfg_tfaw | input | 8 | Four-activate window length |
| cmd_grant | output | 1 | Offered command may issue this cycle |
| rd_data_valid | output | 1 | Nominal read data strobe |

## Verification
The hardest state to reach is a rank whose fifth activate is blocked only by the four-activate window and by no other limit. Reaching it needs four activates to four different banks, each spaced exactly at tRRD. The window is also programmed longer than 4·tRRD, so that the fifth attempt is refused while its tRRD has already expired. The stimulus then probes that rank at the cycles just before and exactly at the window boundary. An activate to the other rank is slipped in between to show the window is kept per rank.

// File: rtl/dram_timing_guard.sv
module dram_timing_guard #(
  parameter int RANK_W    = 1,
  parameter int BANK_W    = 3,
  parameter int BURST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [3:0]        cfg_cl,
  input  logic [3:0]        cfg_trp,
  input  logic [3:0]        cfg_trcd,
  input  logic [3:0]        cfg_trrd,
  input  logic [4:0]        cfg_twr,
  input  logic [7:0]        cfg_tfaw,
  output logic              cmd_grant,
  output logic              rd_data_valid
);
  localparam int NR = 1 << RANK_W;
  localparam int NB = 1 << BANK_W;
  localparam int NT = NR * NB;
  localparam int IW = RANK_W + BANK_W;
  localparam int CW = 6;
  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_PRE = 2'd3;

  function automatic logic [7:0] clamp8(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [7:0] cl_e, trp_e, trcd_e, trrd_e, twr_e, tfaw_e, wr_sum;
  assign cl_e   = clamp8({4'd0, cfg_cl},   8'd5, 8'd15);
  assign trp_e  = clamp8({4'd0, cfg_trp},  8'd4, 8'd15);
  assign trcd_e = clamp8({4'd0, cfg_trcd}, 8'd4, 8'd15);
  assign trrd_e = clamp8({4'd0, cfg_trrd}, 8'd4, 8'd15);
  assign twr_e  = clamp8({3'd0, cfg_twr},  8'd5, 8'd16);
  assign tfaw_e = clamp8(cfg_tfaw, {trrd_e[5:0], 2'b00}, 8'd63);
  assign wr_sum = cl_e + 8'(BURST_CYC) + twr_e - 8'd1;

  logic [CW-1:0] ld_rp, ld_rcd, ld_wr, ld_rrd, ld_faw;
  assign ld_rp  = trp_e[CW-1:0]  - 1'b1;
  assign ld_rcd = trcd_e[CW-1:0] - 1'b1;
  assign ld_wr  = wr_sum[CW-1:0];
  assign ld_rrd = trrd_e[CW-1:0] - 1'b1;
  assign ld_faw = tfaw_e[CW-1:0] - 1'b1;

  logic [IW-1:0]  idx;
  logic [NT-1:0]  is_open, bsel;
  logic [NR-1:0]  rsel;
  logic [CW-1:0]  rp_cnt [NT];
  logic [CW-1:0]  rcd_cnt[NT];
  logic [CW-1:0]  wr_cnt [NT];
  logic [CW-1:0]  rrd_cnt[NR];
  logic [CW-1:0]  faw_cnt[NR][4];
  logic [1:0]     faw_ptr[NR];
  logic [15:0]    rd_sr;
  logic           legal, act_g, rd_g;

  assign idx = {cmd_rank, cmd_bank};

  always_comb begin
    unique case (cmd_op)
      OP_ACT:       legal = !is_open[idx] && rp_cnt[idx] == '0 && rrd_cnt[cmd_rank] == '0
                            && faw_cnt[cmd_rank][faw_ptr[cmd_rank]] == '0;
      OP_RD, OP_WR: legal = is_open[idx] && rcd_cnt[idx] == '0;
      default:      legal = is_open[idx] && wr_cnt[idx] == '0;
    endcase
  end

  assign cmd_grant     = cmd_valid && legal;
  assign act_g         = cmd_grant && cmd_op == OP_ACT;
  assign rd_g          = cmd_grant && cmd_op == OP_RD;
  assign rd_data_valid = rd_sr[0];

  always_comb begin
    bsel = '0;
    rsel = '0;
    if (cmd_grant) begin
      bsel[idx]      = 1'b1;
      rsel[cmd_rank] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= '0;
      rd_sr   <= '0;
      for (int i = 0; i < NT; i++) begin
        rp_cnt[i]  <= '0;
        rcd_cnt[i] <= '0;
        wr_cnt[i]  <= '0;
      end
      for (int r = 0; r < NR; r++) begin
        rrd_cnt[r] <= '0;
        faw_ptr[r] <= '0;
        for (int j = 0; j < 4; j++) faw_cnt[r][j] <= '0;
      end
    end else begin
      rd_sr <= (rd_sr >> 1) | (rd_g ? (16'd1 << (cl_e[3:0] - 4'd1)) : 16'd0);
      for (int i = 0; i < NT; i++) begin
        if (bsel[i] && cmd_op == OP_ACT) is_open[i] <= 1'b1;
        if (bsel[i] && cmd_op == OP_PRE) is_open[i] <= 1'b0;
        rp_cnt[i]  <= (bsel[i] && cmd_op == OP_PRE) ? ld_rp  : dec(rp_cnt[i]);
        rcd_cnt[i] <= (bsel[i] && cmd_op == OP_ACT) ? ld_rcd : dec(rcd_cnt[i]);
        wr_cnt[i]  <= (bsel[i] && cmd_op == OP_WR)  ? ld_wr  : dec(wr_cnt[i]);
      end
      for (int r = 0; r < NR; r++) begin
        rrd_cnt[r] <= (rsel[r] && act_g) ? ld_rrd : dec(rrd_cnt[r]);
        if (rsel[r] && act_g) faw_ptr[r] <= faw_ptr[r] + 2'd1;
        for (int j = 0; j < 4; j++)
          faw_cnt[r][j] <= (rsel[r] && act_g && faw_ptr[r] == 2'(j)) ? ld_faw : dec(faw_cnt[r][j]);
      end
    end
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_g |=> is_open[$past(idx)]);

  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_grant && cmd_op == OP_PRE) |=> (!is_open[$past(idx)] && rp_cnt[$past(idx)] == $past(ld_rp)));

  // R6
  rrd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_g |=> rrd_cnt[$past(cmd_rank)] == $past(ld_rrd));

  // R7
  faw_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_g |=> faw_cnt[$past(cmd_rank)][$past(faw_ptr[cmd_rank])] == $past(ld_faw));

  // R8
  rd_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_g |=> rd_sr[$past(cl_e[3:0]) - 4'd1]);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(is_open));
endmodule

// File: tb/dram_timing_guard_tb.sv
`timescale 1ns/1ps
module dram_timing_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [0:0] cmd_rank = 1'b0;
  logic [2:0] cmd_bank = 3'd0;
  logic [3:0] cfg_cl = 4'd6, cfg_trp = 4'd6, cfg_trcd = 4'd6, cfg_trrd = 4'd4;
  logic [4:0] cfg_twr = 5'd6;
  logic [7:0] cfg_tfaw = 8'd20;
  logic cmd_grant, rd_data_valid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_timing_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cfg_cl(cfg_cl), .cfg_trp(cfg_trp),
    .cfg_trcd(cfg_trcd), .cfg_trrd(cfg_trrd), .cfg_twr(cfg_twr), .cfg_tfaw(cfg_tfaw),
    .cmd_grant(cmd_grant), .rd_data_valid(rd_data_valid));

  // {gap[16:12], valid[11], op[10:9], rank[8], bank[7:5], expected grant[4], req[3:0]}
  localparam logic [16:0] VEC [24] = '{
    {5'd0,  1'b0, 2'd0, 1'b0, 3'd2, 1'b0, 4'd11}, // R11 idle activate
    {5'd0,  1'b1, 2'd1, 1'b0, 3'd2, 1'b0, 4'd11}, // R11 bank still closed
    {5'd0,  1'b1, 2'd1, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 read to closed bank
    {5'd0,  1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 activate
    {5'd0,  1'b1, 2'd0, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 activate to open bank
    {5'd3,  1'b1, 2'd1, 1'b0, 3'd0, 1'b0, 4'd3},  // R3 spacing 5
    {5'd0,  1'b1, 2'd1, 1'b0, 3'd0, 1'b1, 4'd3},  // R3 spacing 6
    {5'd0,  1'b1, 2'd3, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 precharge
    {5'd4,  1'b1, 2'd0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 spacing 5
    {5'd0,  1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 4'd4},  // R4 spacing 6
    {5'd4,  1'b1, 2'd2, 1'b0, 3'd0, 1'b0, 4'd3},  // R3 write too early
    {5'd0,  1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 4'd3},  // R3 write
    {5'd13, 1'b1, 2'd3, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 spacing 14
    {5'd0,  1'b1, 2'd3, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 spacing 15
    {5'd0,  1'b1, 2'd3, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 spacing 16
    {5'd0,  1'b1, 2'd0, 1'b1, 3'd0, 1'b1, 4'd6},  // R6 rank1 first
    {5'd2,  1'b1, 2'd0, 1'b1, 3'd1, 1'b0, 4'd6},  // R6 spacing 3
    {5'd0,  1'b1, 2'd0, 1'b1, 3'd1, 1'b1, 4'd6},  // R6 spacing 4
    {5'd3,  1'b1, 2'd0, 1'b1, 3'd2, 1'b1, 4'd7},  // R7 third
    {5'd3,  1'b1, 2'd0, 1'b1, 3'd3, 1'b1, 4'd7},  // R7 fourth
    {5'd0,  1'b1, 2'd0, 1'b0, 3'd1, 1'b1, 4'd10}, // R10 other rank free
    {5'd2,  1'b1, 2'd0, 1'b1, 3'd4, 1'b0, 4'd7},  // R7 fifth at +16
    {5'd2,  1'b1, 2'd0, 1'b1, 3'd4, 1'b0, 4'd7},  // R7 fifth at +19
    {5'd0,  1'b1, 2'd0, 1'b1, 3'd4, 1'b1, 4'd7}   // R7 fifth at +20
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic r, input logic [2:0] b);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_rank = r; cmd_bank = b;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 1'b0, 3'd0);
  endtask

  task automatic rd_window(input int lat, input string tag);
    chk(rd_data_valid, 1'b0, tag);
    for (int k = 1; k <= 10; k++) begin
      idle(1);
      chk(rd_data_valid, (k == lat), tag);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk(rd_data_valid, 1'b0, "R1");

    foreach (VEC[n]) begin
      idle(int'(VEC[n][16:12]));
      drive(VEC[n][11], VEC[n][10:9], VEC[n][8], VEC[n][7:5]);
      checks++;
      if (cmd_grant !== VEC[n][4]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%0b expected=%0b", VEC[n][3:0], n, cmd_grant, VEC[n][4]);
      end
    end

    // R8: read latency 6
    idle(2);
    drive(1'b1, 2'd0, 1'b0, 3'd3); chk(cmd_grant, 1'b1, "R8");
    idle(5);
    drive(1'b1, 2'd1, 1'b0, 3'd3); chk(cmd_grant, 1'b1, "R8");
    rd_window(6, "R8");

    // R9: CL=2 clamps to 5, tRCD=1 clamps to 4
    cfg_cl = 4'd2; cfg_trcd = 4'd1;
    drive(1'b1, 2'd0, 1'b0, 3'd6); chk(cmd_grant, 1'b1, "R9");
    idle(2);
    drive(1'b1, 2'd1, 1'b0, 3'd6); chk(cmd_grant, 1'b0, "R9");
    drive(1'b1, 2'd1, 1'b0, 3'd6); chk(cmd_grant, 1'b1, "R9");
    rd_window(5, "R9");
    cfg_cl = 4'd6; cfg_trcd = 4'd6;

    // R1: reset closes an open bank
    idle(4);
    drive(1'b1, 2'd0, 1'b0, 3'd5); chk(cmd_grant, 1'b1, "R1");
    idle(1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    drive(1'b1, 2'd1, 1'b0, 3'd5); chk(cmd_grant, 1'b0, "R1");
    chk(rd_data_valid, 1'b0, "R1");
    idle(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule